// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block takes one parallel data word over a valid/ready handshake and sends it on a single serial line as an asynchronous frame. The frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and a high stop period. No clock travels with the data. Both ends agree on the bit rate beforehand, and the rate is set here by a divisor input.

The frame shape is chosen at run time by three small format inputs. The stop period may be half a bit, one bit, one and a half bits or two bits long. Timing therefore runs on a half-bit tick, so the fractional stop lengths come out exact. Parity can be odd, even, forced low, forced high or absent. The divisor gives the length of half a bit in clock cycles. With the default 16-bit divisor, common rates such as 4800, 9600 and 115200 baud are reachable from system clocks of tens of MHz.

The block captures the word, the format and the divisor together when it accepts a word. It holds ready low until the stop period has ended. While no frame is being sent, the line rests high.

Top module: `async_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, txLine is 1, inReady is 1 and busy is 0.
- R2: A word is accepted on a rising clock edge where inValid and inReady are both 1. From the next cycle, busy is 1 and inReady is 0 until the last stop half-bit has ended. On the edge that ends it, inReady returns to 1 and busy returns to 0.
- R3: The frame begins in the cycle after acceptance with a start bit at 0 lasting one bit time.
- R4: Data bits follow the start bit directly, least significant bit first. dataLen code 0, 1, 2, 3 selects 5, 6, 7, 8 bits. inData bits above the selected length have no effect on the line.
- R5: parityMode code 1 = odd (data ones plus parity bit total odd), 2 = even (total even), 3 = parity bit always 0, 4 = parity bit always 1. Codes 0 and 5 to 7 send no parity bit. When present, the parity bit lasts one bit time and follows the last data bit.
- R6: The frame ends with the line at 1 for stopLen code + 1 half-bit times: code 0, 1, 2, 3 gives 0.5, 1, 1.5, 2 bit times.
- R7: One half-bit lasts H clock cycles, where H is halfDiv, and halfDiv = 0 is treated as 1. Every start, data and parity bit lasts exactly 2H cycles.
- R8: Divisor, format and data are sampled at acceptance. Changing halfDiv, dataLen, parityMode, stopLen or inData during a frame does not alter that frame.
- R9: inValid asserted while a frame is in progress is ignored: no word is taken and the running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halfDiv | input | DIV_W | Half-bit period in clock cycles (0 acts as 1) |
| dataLen | input | 2 | Data length code, 5 + code bits |
| parityMode | input | 3 | Parity selection code |
| stopLen | input | 2 | Stop length code, code + 1 half-bits |
| inValid | input | 1 | Data word offered |
| inData | input | 8 | Data word |
| inReady | output | 1 | Block can take a word |
| txLine | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with the default DIV_W of 16. That width lets one frame run with a half-bit of 217 cycles, a divisor for 115200 baud from a 50 MHz clock. The other frames use half-bits of 0 through 4 cycles, so every length, parity code and stop code is covered within a short run, including the single-cycle half-bit where the tick fires on every cycle. Line levels are checked for every cycle of every half-bit, which tests both the exact bit boundaries and the fractional stop periods.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } txState_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic emitParity;
    logic emitStop;
  } txStrobe_t;

  localparam int WORD_W = 8;
  localparam int MIN_LEN = 5;
endpackage

// File: rtl/async_tx_tick.sv
module async_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             tick
);
  logic [DIV_W-1:0] divLat;
  logic [DIV_W-1:0] cnt;

  assign tick = active && (cnt == divLat - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divLat <= DIV_W'(1);
      cnt    <= '0;
    end else if (load) begin
      divLat <= (halfDiv == '0) ? DIV_W'(1) : halfDiv;
      cnt    <= '0;
    end else if (!active || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divLat > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic [1:0] dataLen,
  input  logic [2:0] parityMode,
  input  logic [1:0] stopLen,
  input  logic      tick,
  output txStrobe_t strb,
  output logic      frameActive,
  output logic      inReady
);
  txState_e   state;
  logic       half;
  logic [2:0] bitCnt;
  logic [2:0] lastBit;
  logic       parOn;
  logic [2:0] stopHalves;
  logic [2:0] stopLeft;

  assign inReady     = (state == ST_IDLE);
  assign frameActive = !inReady;

  always_comb begin
    strb      = '0;
    strb.load = inReady && inValid;
    if (tick && half) begin
      unique case (state)
        ST_START: strb.shiftOut = 1'b1;
        ST_DATA: begin
          if (bitCnt != lastBit) strb.shiftOut = 1'b1;
          else if (parOn)        strb.emitParity = 1'b1;
          else                   strb.emitStop = 1'b1;
        end
        ST_PAR:  strb.emitStop = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      half       <= 1'b0;
      bitCnt     <= '0;
      lastBit    <= '0;
      parOn      <= 1'b0;
      stopHalves <= 3'd1;
      stopLeft   <= 3'd1;
    end else begin
      unique case (state)
        ST_IDLE: if (strb.load) begin
          state      <= ST_START;
          half       <= 1'b0;
          bitCnt     <= '0;
          lastBit    <= 3'(MIN_LEN - 1) + {1'b0, dataLen};
          parOn      <= (parityMode != 3'd0) && (parityMode < 3'd5);
          stopHalves <= {1'b0, stopLen} + 3'd1;
        end
        ST_START, ST_DATA, ST_PAR: if (tick) begin
          half <= !half;
          if (half) begin
            if (state == ST_START) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end else if (state == ST_DATA && bitCnt != lastBit) begin
              bitCnt <= bitCnt + 3'd1;
            end else begin
              state    <= (state == ST_DATA && parOn) ? ST_PAR : ST_STOP;
              stopLeft <= stopHalves;
            end
          end
        end
        ST_STOP: if (tick) begin
          if (stopLeft == 3'd1) state <= ST_IDLE;
          else                  stopLeft <= stopLeft - 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  // R7
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !tick);
  // R6
  stop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> (stopLeft != 3'd0 && stopLeft <= 3'd4));
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strb,
  input  logic [WORD_W-1:0] inData,
  input  logic [1:0]        dataLen,
  input  logic [2:0]        parityMode,
  input  logic              frameActive,
  output logic              txLine
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] masked;
  logic              parBit;
  logic              parNext;
  logic              lineReg;

  always_comb begin
    for (int i = 0; i < WORD_W; i++)
      masked[i] = inData[i] && (i < MIN_LEN + int'(dataLen));
    unique case (parityMode)
      3'd1:    parNext = ~^masked;
      3'd2:    parNext = ^masked;
      3'd4:    parNext = 1'b1;
      default: parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      lineReg  <= 1'b1;
    end else if (strb.load) begin
      shiftReg <= masked;
      parBit   <= parNext;
      lineReg  <= 1'b0;
    end else if (strb.shiftOut) begin
      lineReg  <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strb.emitParity) begin
      lineReg <= parBit;
    end else if (strb.emitStop) begin
      lineReg <= 1'b1;
    end
  end

  assign txLine = lineReg;

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameActive |-> txLine);
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> !txLine);
  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.emitStop |=> txLine);
endmodule

// File: rtl/async_serial_tx.sv
module async_serial_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [1:0]       dataLen,
  input  logic [2:0]       parityMode,
  input  logic [1:0]       stopLen,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  output logic             txLine,
  output logic             busy
);
  txStrobe_t strb;
  logic      tick;
  logic      frameActive;

  async_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .dataLen(dataLen),
    .parityMode(parityMode), .stopLen(stopLen), .tick(tick),
    .strb(strb), .frameActive(frameActive), .inReady(inReady)
  );

  async_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(strb.load), .active(frameActive),
    .halfDiv(halfDiv), .tick(tick)
  );

  async_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inData(inData),
    .dataLen(dataLen), .parityMode(parityMode),
    .frameActive(frameActive), .txLine(txLine)
  );

  assign busy = frameActive;
endmodule

// File: tb/async_serial_tx_tb.sv
module async_serial_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] halfDiv = '0;
  logic [1:0] dataLen = '0;
  logic [2:0] parityMode = '0;
  logic [1:0] stopLen = '0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, txLine, busy;

  int errors = 0;
  int checks = 0;
  bit monBusy = 0;

  typedef struct {
    logic [31:0] pat;
    int halves;
    int dataHalves;
    int parHalves;
    int h;
    string tag;
  } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_serial_tx #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .halfDiv(halfDiv), .dataLen(dataLen),
    .parityMode(parityMode), .stopLen(stopLen), .inValid(inValid),
    .inData(inData), .inReady(inReady), .txLine(txLine), .busy(busy)
  );

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  // expected half-bit levels of one frame, built from the requirements
  task automatic sendWord(input logic [7:0] d, input int lenCode, input int pm,
                          input int sc, input int hdiv, input string tag,
                          input bit scramble, input bit poke);
    item_t it;
    int n, k, ones;
    n = 5 + lenCode;
    it.pat = '0;
    k = 2;                                   // R3 start halves stay 0
    ones = 0;
    for (int i = 0; i < n; i++) begin        // R4 LSB first
      it.pat[k] = d[i]; it.pat[k+1] = d[i];
      ones += int'(d[i]);
      k += 2;
    end
    it.dataHalves = 2 * n;
    it.parHalves = 0;
    if (pm >= 1 && pm <= 4) begin            // R5
      logic p;
      p = (pm == 1) ? ((ones % 2) == 0) : (pm == 2) ? ((ones % 2) == 1) : (pm == 4);
      it.pat[k] = p; it.pat[k+1] = p;
      k += 2;
      it.parHalves = 2;
    end
    for (int i = 0; i <= sc; i++) begin      // R6
      it.pat[k] = 1'b1; k++;
    end
    it.halves = k;
    it.h = (hdiv == 0) ? 1 : hdiv;           // R7
    it.tag = tag;

    @(negedge clk);
    while (!inReady) @(negedge clk);
    halfDiv = DIV_W'(hdiv); dataLen = 2'(lenCode); parityMode = 3'(pm);
    stopLen = 2'(sc); inData = d; inValid = 1'b1;
    expQ.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
    if (scramble) begin                      // R8
      halfDiv = DIV_W'(hdiv + 3); dataLen = ~2'(lenCode); parityMode = 3'(pm ^ 3);
      stopLen = ~2'(sc); inData = ~d;
    end
    if (poke) begin                          // R9
      repeat (3) @(negedge clk);
      inData = 8'hFF; parityMode = 3'd4; inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: pops each expected frame and compares it cycle by cycle
  initial begin
    item_t it;
    bit good;
    @(posedge rst_n);
    forever begin
      do @(negedge clk); while (txLine !== 1'b0);
      monBusy = 1;
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected frame started", 0, 1);
      end else begin
        it = expQ.pop_front();
        check(busy === 1'b1 && inReady === 1'b0, {it.tag, " R2 busy at start"}, busy, 1);
        for (int k = 0; k < it.halves; k++) begin
          string fld;
          good = 1;
          for (int c = 0; c < it.h; c++) begin
            if (!(k == 0 && c == 0)) @(negedge clk);
            if (txLine !== it.pat[k]) good = 0;
            if (k == it.halves - 1 && c == it.h - 1 && busy !== 1'b1) good = 0;
          end
          if (k < 2) fld = "R3";
          else if (k < 2 + it.dataHalves) fld = "R4";
          else if (k < 2 + it.dataHalves + it.parHalves) fld = "R5";
          else fld = "R6";
          check(good, $sformatf("%s %s/R7 half %0d", it.tag, fld, k), int'(txLine), int'(it.pat[k]));
        end
        @(negedge clk);
        check(inReady === 1'b1 && busy === 1'b0 && txLine === 1'b1,
              {it.tag, " R2/R6 ready after stop"}, inReady, 1);
      end
      monBusy = 0;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired: got %0d cycles expected fewer", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txLine === 1'b1 && inReady === 1'b1 && busy === 1'b0, "R1 reset state", txLine, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(txLine === 1'b1 && inReady === 1'b1 && busy === 1'b0, "R1 idle after reset", inReady, 1);

    sendWord(8'hA5, 3, 0, 1, 2, "R4 len8 none", 0, 0);
    sendWord(8'h13, 0, 1, 0, 3, "R5 odd half-stop", 0, 0);
    sendWord(8'hFF, 0, 2, 2, 1, "R4 upper bits ignored even", 0, 0);
    sendWord(8'h6C, 1, 3, 3, 2, "R5 space two-stop", 0, 0);
    sendWord(8'h00, 2, 4, 1, 0, "R7 div zero mark", 0, 0);
    sendWord(8'h3C, 3, 1, 2, 2, "R8 inputs changed mid-frame", 1, 0);
    sendWord(8'h81, 3, 2, 1, 4, "R9 valid while busy", 0, 1);
    sendWord(8'h5A, 2, 6, 0, 1, "R5 code6 none", 0, 0);
    sendWord(8'hC3, 3, 0, 1, 217, "R7 115200 divisor", 0, 0);
    for (int i = 0; i < 4; i++)
      sendWord(8'(8'h29 * (i + 1)), i, i + 1, 3 - i, 1, "R2 back-to-back", 0, 0);

    @(negedge clk);
    while (expQ.size() != 0 || monBusy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(txLine === 1'b1 && inReady === 1'b1 && busy === 1'b0, "R1 idle at end", txLine, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule